// File: doc/BRIEF.md
# Two-Stage SPI Baud Generator

This block derives the bit-rate timing for a serial peripheral engine from the peripheral clock. Each channel chains two dividers. The first is a programmable prescaler that divides by 1 to 32. The second is a power-of-two stage that divides by 2, 4, 8, 16 or 32, or is bypassed. Each channel produces two outputs. The first is a one-cycle tick at the divided rate, which the shifter uses as its clock enable. The second is a square wave that toggles on every tick.

Two channels are built, one for transmit and one for receive. Each has its own 16-bit clock-select register, written as one half-word. A steering input makes the receive channel take the transmit setting and restart together with it. Choosing a ratio for a target bit rate is left to software. Every write to a select register clears that channel's counters, so the new rate starts from a known phase.

Top module: `baud_gen`

## Requirements
- R1: Synchronous reset clears both select registers, so each channel divides by 2. During reset no tick is raised and both square waves are low. In the first cycle after reset no tick is raised; the first tick comes in the second cycle.
- R2: Select bits 12:8 hold the prescale factor minus one. The prescale factor P, from 1 to 32, multiplies the total ratio.
- R3: Select bits 2:0 set the power-of-two divisor D. Codes 0, 1, 2, 3 and 4 give 2, 4, 8, 16 and 32. Code 7 gives 1, which bypasses the stage. The tick period is P*D cycles.
- R4: The reserved codes 5 and 6 behave exactly like code 0 (divide by 2).
- R5: A write clears the channel's counters. Count the cycle after the capturing edge as cycle 0. The first tick is high in cycle P*D-1, the next in cycle 2*P*D-1, and none comes between them.
- R6: With P*D equal to 1, the tick is high in every cycle, including the cycle right after a write.
- R7: The square wave is cleared by reset and by a write. It inverts on the edge that ends each tick cycle and holds otherwise, so it goes high in cycle P*D.
- R8: Select bits 15:13 and 7:3 have no effect on the tick timing.
- R9: While rx_follow_tx is high, the receive channel uses the transmit setting and restarts on transmit writes. Receive writes change nothing that can be seen on the receive outputs while the channel follows.
- R10: While rx_follow_tx is low, the receive channel runs from its own register. The value it uses is the last one written, including a value written while it followed. Any change of rx_follow_tx restarts the receive counters in the same way as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_sel_wr | input | 1 | Write strobe for the transmit select register |
| tx_sel_data | input | 16 | Transmit select value |
| rx_sel_wr | input | 1 | Write strobe for the receive select register |
| rx_sel_data | input | 16 | Receive select value |
| rx_follow_tx | input | 1 | Receive channel takes the transmit setting |
| tx_tick | output | 1 | Transmit bit-rate enable, one cycle per period |
| tx_sck | output | 1 | Transmit square wave, toggles per tick |
| rx_tick | output | 1 | Receive bit-rate enable |
| rx_sck | output | 1 | Receive square wave |

## Verification
The bench sweeps all 32 prescale values against all 8 divider codes and fills the reserved bits with seeded random data. This exposes a prescale field shifted by one bit or off by one count, a wrong divisor for one code, and reserved codes or reserved bits that leak into the ratio. For each setting the bench checks the position of the first tick after the write, which a design that failed to restart its counters would get wrong. It also checks the spacing to the second tick and the edge on which the square wave rises. The ratio-1 bypass is a separate corner, because a design that counted one extra cycle there would leave gaps in the tick. The bench also walks the receive channel through following, ignoring its own writes, and releasing. A missed restart on a change of the steering input would shift the phase of the receive ticks, and a missed store of a write made while following would show up as the wrong receive ratio after release.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int SEL_W     = 16;
    localparam int PRE_LSB   = 8;
    localparam int PRE_W     = 5;
    localparam int DIV_W     = 3;
    localparam int DIVCNT_W  = 5;
    localparam int NUM_CH    = 2;
    localparam int CH_TX     = 0;
    localparam int CH_RX     = 1;

    typedef enum logic [DIV_W-1:0] {
        DIV_BY2   = 3'd0,
        DIV_BY4   = 3'd1,
        DIV_BY8   = 3'd2,
        DIV_BY16  = 3'd3,
        DIV_BY32  = 3'd4,
        DIV_RSV5  = 3'd5,
        DIV_RSV6  = 3'd6,
        DIV_BYONE = 3'd7
    } div_code_e;

    typedef struct packed {
        logic [PRE_W-1:0]    pre_last;
        logic [DIVCNT_W-1:0] div_last;
    } rate_cfg_t;

    function automatic logic [DIVCNT_W-1:0] div_terminal(input div_code_e code);
        logic [DIVCNT_W-1:0] t;
        case (code)
            DIV_BY2, DIV_BY4, DIV_BY8, DIV_BY16, DIV_BY32:
                t = DIVCNT_W'((1 << (int'(code) + 1)) - 1);
            DIV_BYONE: t = '0;
            default:   t = DIVCNT_W'(1);
        endcase
        return t;
    endfunction

    function automatic rate_cfg_t decode_sel(input logic [SEL_W-1:0] sel);
        rate_cfg_t c;
        c.pre_last = sel[PRE_LSB +: PRE_W];
        c.div_last = div_terminal(div_code_e'(sel[DIV_W-1:0]));
        return c;
    endfunction

endpackage

// File: rtl/baud_sel_reg.sv
module baud_sel_reg
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] sel_q
);
    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (wr)
            sel_q <= wdata;
    end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre_last,
    output logic             pre_tick
);
    logic [PRE_W-1:0] cnt_q;

    assign pre_tick = (cnt_q >= pre_last);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else if (pre_tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/baud_pow2_stage.sv
module baud_pow2_stage
    import baud_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                pre_tick,
    input  logic [DIVCNT_W-1:0] div_last,
    output logic                tick
);
    logic [DIVCNT_W-1:0] cnt_q;
    logic                wrap;

    assign wrap = (cnt_q >= div_last);
    assign tick = pre_tick && wrap;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else if (pre_tick)
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/baud_channel.sv
module baud_channel
    import baud_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  rate_cfg_t cfg,
    output logic      tick,
    output logic      sck
);
    logic pre_tick;

    baud_prescaler u_pre (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .pre_last (cfg.pre_last),
        .pre_tick (pre_tick)
    );

    baud_pow2_stage u_pow (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .pre_tick (pre_tick),
        .div_last (cfg.div_last),
        .tick     (tick)
    );

    always_ff @(posedge clk) begin
        if (rst || restart)
            sck <= 1'b0;
        else if (tick)
            sck <= ~sck;
    end
endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_sel_wr,
    input  logic [SEL_W-1:0] tx_sel_data,
    input  logic             rx_sel_wr,
    input  logic [SEL_W-1:0] rx_sel_data,
    input  logic             rx_follow_tx,
    output logic             tx_tick,
    output logic             tx_sck,
    output logic             rx_tick,
    output logic             rx_sck
);
    logic [SEL_W-1:0]  tx_sel_q;
    logic [SEL_W-1:0]  rx_sel_q;
    logic              follow_q;
    rate_cfg_t         ch_cfg [NUM_CH];
    logic [NUM_CH-1:0] ch_restart;
    logic [NUM_CH-1:0] ch_tick;
    logic [NUM_CH-1:0] ch_sck;

    baud_sel_reg u_tx_sel (
        .clk   (clk),
        .rst   (rst),
        .wr    (tx_sel_wr),
        .wdata (tx_sel_data),
        .sel_q (tx_sel_q)
    );

    baud_sel_reg u_rx_sel (
        .clk   (clk),
        .rst   (rst),
        .wr    (rx_sel_wr),
        .wdata (rx_sel_data),
        .sel_q (rx_sel_q)
    );

    always_ff @(posedge clk) begin
        follow_q <= rx_follow_tx;
    end

    always_comb begin
        ch_cfg[CH_TX]     = decode_sel(tx_sel_q);
        ch_cfg[CH_RX]     = decode_sel(rx_follow_tx ? tx_sel_q : rx_sel_q);
        ch_restart[CH_TX] = tx_sel_wr;
        ch_restart[CH_RX] = (rx_follow_tx ? tx_sel_wr : rx_sel_wr)
                          || (rx_follow_tx != follow_q);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        baud_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .restart (ch_restart[g]),
            .cfg     (ch_cfg[g]),
            .tick    (ch_tick[g]),
            .sck     (ch_sck[g])
        );
    end

    assign tx_tick = ch_tick[CH_TX];
    assign tx_sck  = ch_sck[CH_TX];
    assign rx_tick = ch_tick[CH_RX];
    assign rx_sck  = ch_sck[CH_RX];
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        tx_sel_wr,
    input logic [15:0] tx_sel_data,
    input logic [15:0] tx_sel_q,
    input logic        rx_follow_tx,
    input logic        tx_tick,
    input logic        tx_sck,
    input logic        rx_tick,
    input logic        rx_sck
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!tx_tick && !rx_tick && !tx_sck && !rx_sck));

    assert_restart_no_tick_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_sel_wr && !(tx_sel_data[12:8] == 5'd0 && tx_sel_data[2:0] == 3'd7))
        |=> !tx_tick);

    assert_restart_sck_low_R7: assert property (@(posedge clk) disable iff (rst)
        tx_sel_wr |=> !tx_sck);

    assert_unit_ratio_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_sel_q[12:8] == 5'd0 && tx_sel_q[2:0] == 3'd7) |-> tx_tick);

    assert_sck_flip_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_tick && !tx_sel_wr) |=> (tx_sck != $past(tx_sck)));

    assert_sck_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!tx_tick && !tx_sel_wr) |=> $stable(tx_sck));

    assert_follow_sync_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_follow_tx && tx_sel_wr) |=>
        (!rx_follow_tx || (rx_tick == tx_tick && rx_sck == tx_sck)));
endmodule

bind baud_gen baud_gen_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_sel_wr    (tx_sel_wr),
    .tx_sel_data  (tx_sel_data),
    .tx_sel_q     (tx_sel_q),
    .rx_follow_tx (rx_follow_tx),
    .tx_tick      (tx_tick),
    .tx_sck       (tx_sck),
    .rx_tick      (rx_tick),
    .rx_sck       (rx_sck)
);

// File: tb/test_baud_gen.sv
`timescale 1ns/1ps
module test_baud_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_sel_wr = 1'b0;
    logic [15:0] tx_sel_data = '0;
    logic        rx_sel_wr = 1'b0;
    logic [15:0] rx_sel_data = '0;
    logic        rx_follow_tx = 1'b0;
    logic        tx_tick, tx_sck, rx_tick, rx_sck;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    baud_gen i_baud_gen (
        .clk(clk), .rst(rst),
        .tx_sel_wr(tx_sel_wr), .tx_sel_data(tx_sel_data),
        .rx_sel_wr(rx_sel_wr), .rx_sel_data(rx_sel_data),
        .rx_follow_tx(rx_follow_tx),
        .tx_tick(tx_tick), .tx_sck(tx_sck),
        .rx_tick(rx_tick), .rx_sck(rx_sck)
    );

    function automatic int ratio_of(input logic [15:0] sel);
        int d;
        case (sel[2:0])
            3'd0: d = 2;
            3'd1: d = 4;
            3'd2: d = 8;
            3'd3: d = 16;
            3'd4: d = 32;
            3'd7: d = 1;
            default: d = 2;
        endcase
        return (int'(sel[12:8]) + 1) * d;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write on one negedge, return at the next negedge (cycle 0 after capture).
    task automatic wr_sel(input bit rx, input logic [15:0] v);
        @(negedge clk);
        if (rx) begin rx_sel_wr = 1'b1; rx_sel_data = v; end
        else    begin tx_sel_wr = 1'b1; tx_sel_data = v; end
        @(negedge clk);
        tx_sel_wr = 1'b0;
        rx_sel_wr = 1'b0;
    endtask

    // Sample from cycle 0 (current negedge) for 2n+1 cycles.
    task automatic measure(input bit rx, input int n, input string req);
        int bad_idx = -1;
        int first = -1;
        bit sck_bad = 1'b0;
        for (int idx = 0; idx <= 2 * n; idx++) begin
            logic t, s;
            if (idx > 0) @(negedge clk);
            t = rx ? rx_tick : tx_tick;
            s = rx ? rx_sck : tx_sck;
            if (t && first < 0) first = idx;
            if (idx < 2 * n && bad_idx < 0 &&
                (t != ((n == 1) || idx == n - 1 || idx == 2 * n - 1)))
                bad_idx = idx;
            if (idx == n - 1 && s != 1'b0) sck_bad = 1'b1;
            if (idx == n && s != 1'b1) sck_bad = 1'b1;
        end
        check(bad_idx < 0, {req, " tick pattern (first tick cycle)"}, first, n - 1);
        check(!sck_bad, {req, " R7 square wave edge"}, int'(sck_bad), 0);
    endtask

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'h5eed);
        // R1: during reset
        repeat (3) @(negedge clk);
        check(!tx_tick && !rx_tick && !tx_sck && !rx_sck, "R1 in reset",
              int'({tx_tick, rx_tick, tx_sck, rx_sck}), 0);
        rst = 1'b0;
        measure(1'b0, 2, "R1 tx after reset");
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        measure(1'b1, 2, "R1 rx after reset");

        // R6 directed ratio 1, R4 reserved codes, R8 reserved bits
        wr_sel(1'b0, 16'h0007); measure(1'b0, 1, "R6 ratio one");
        wr_sel(1'b0, 16'h0305); measure(1'b0, 8, "R4 code5");
        wr_sel(1'b0, 16'h0306); measure(1'b0, 8, "R4 code6");
        wr_sel(1'b0, 16'hE0F9); measure(1'b0, 4, "R8 reserved ones");
        wr_sel(1'b0, 16'h1F04); measure(1'b0, 1024, "R2 R3 max ratio");

        // R2 R3 R8 sweep with random reserved bits
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 32; p++) begin
                logic [15:0] v;
                v = 16'($urandom) & 16'hE0F8;
                v[12:8] = 5'(p);
                v[2:0]  = 3'(c);
                wr_sel(1'b0, v);
                measure(1'b0, ratio_of(v), "R2 R3 R8 sweep");
            end
        end

        // R5 restart mid-period
        wr_sel(1'b0, 16'h0201);
        repeat (5) @(negedge clk);
        wr_sel(1'b0, 16'h0201);
        measure(1'b0, 12, "R5 restart mid-period");

        // R9 follow: rx write ignored, rx tracks tx
        @(negedge clk); rx_follow_tx = 1'b1;
        wr_sel(1'b1, 16'h0302);
        wr_sel(1'b0, 16'h0001);
        measure(1'b1, 4, "R9 rx follows tx");
        check(rx_tick == tx_tick, "R9 rx equals tx", int'(rx_tick), int'(tx_tick));
        wr_sel(1'b0, 16'h0101);
        measure(1'b1, 8, "R9 rx restarts on tx write");

        // R10 release: own stored value, tie change restarts
        @(negedge clk); rx_follow_tx = 1'b0;
        @(negedge clk);
        measure(1'b1, ratio_of(16'h0302), "R10 release restart");
        wr_sel(1'b1, 16'h0204);
        measure(1'b1, 96, "R10 rx own write");
        wr_sel(1'b0, 16'h0000);
        measure(1'b0, 2, "R10 tx independent");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule